// File: doc/BRIEF.md
# Predicated Paired-Lane Vector Loader

This block carries out a structure load that fills two vector destinations from memory. A vector of `VLEN` bits is split into 128-bit lanes. Memory holds 128-bit items in consecutive pairs. For lane i, the lower-addressed item of pair i goes to lane i of destination A, and the higher-addressed item goes to lane i of destination B. The operation starts from a base address plus a signed immediate scaled by the vector length in bytes. A predicate with one bit per lane decides which pairs are fetched at all.

Reads go out one at a time, in ascending address order, on a simple valid/ready request port. The responses come back on a response port, each with an error flag. A lane whose predicate bit is clear produces no traffic, so it can never fault, and it reads back as zero in both destinations. An error on an active lane ends the operation with a fault and the lane number, and the destinations are not committed. When the operation finishes, a one-cycle done pulse presents both vectors and the two destination register numbers. Destination B is always the register after A, modulo 32.

Top module: `vec_pair_loader`

## Requirements
- R1: The start address is `base_addr + imm * (VLEN/8)`, where `imm` is a two's-complement signed value of `IMM_W` bits. Item k is read at the start address plus 16·k, and lane i reads items 2i and 2i+1.
- R2: On a commit, bits [128i+127:128i] of `vec_a` hold the data of item 2i, and the same bits of `vec_b` hold the data of item 2i+1, for every active lane i.
- R3: No request is issued for either item of a lane whose `pred` bit is 0.
- R4: Lanes whose `pred` bit is 0 read back as all-zero in both `vec_a` and `vec_b` when `done` is high.
- R5: Requests within one operation are issued in strictly ascending address order.
- R6: At most one request is outstanding. After a request handshake, `req_valid` stays low until the matching response has been accepted.
- R7: If an accepted response has `rsp_err` set, the block asserts `done` with `fault`=1 and `commit`=0. `fault_lane` gives the lane of that response, which is the lowest faulting active lane. No further requests are issued.
- R8: If all `pred` bits are 0, `done` is high in the cycle after `start`, with `commit`=1, and no request is issued.
- R9: `done` is a single-cycle pulse issued after the last active response has been accepted. `commit` is high with it when no fault occurred.
- R10: `idx_a` returns the `dst_idx` captured at `start`, and `idx_b` equals `idx_a`+1 modulo 32 (so 31 is followed by 0).
- R11: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an operation when the block is idle |
| base_addr | input | AW | Base byte address |
| imm | input | IMM_W | Signed immediate, scaled by VLEN/8 |
| pred | input | VLEN/128 | One enable bit per 128-bit lane |
| dst_idx | input | 5 | Register number of destination A |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | AW | Byte address of the 128-bit read |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 128 | Read response data |
| rsp_err | input | 1 | Read response reports an error |
| done | output | 1 | One-cycle completion pulse |
| commit | output | 1 | Destinations may be written (done and no fault) |
| fault | output | 1 | An active lane faulted |
| fault_lane | output | max(1,log2(VLEN/128)) | Lane index of the fault |
| idx_a | output | 5 | Register number for `vec_a` |
| idx_b | output | 5 | Register number for `vec_b` |
| vec_a | output | VLEN | First items of each pair |
| vec_b | output | VLEN | Second items of each pair |

## Verification
The bound checker checks the following on every cycle: that only one request is outstanding, that requests rise in order, that no request reaches a masked lane, that a stalled request is held, that masked lanes are zero at done, that the empty-predicate done comes one cycle after start, and that done is a pulse. The bench scenarios show the parts a cycle-local property cannot: the correct data in each lane of both destinations, the exact start address for negative, positive and unaligned inputs, the stop-on-first-fault sequence with its lane number, and the register-number wrap from 31 to 0.

// File: rtl/vpl_pkg.sv
package vpl_pkg;
   localparam int ITEM_W     = 128;
   localparam int ITEM_SHIFT = 4;
   localparam int PAIR_SHIFT = 5;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } vpl_state_e;
endpackage

// File: rtl/vpl_lane_seek.sv
module vpl_lane_seek #(
   parameter int LANES = 4,
   parameter int LW    = 2,
   parameter int FW    = 3
) (
   input  logic [LANES-1:0] mask,
   input  logic [FW-1:0]    from,
   output logic             found,
   output logic [LW-1:0]    lane
);
   always_comb begin
      found = 1'b0;
      lane  = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (mask[i] && (i >= int'(from))) begin
            found = 1'b1;
            lane  = LW'(i);
         end
      end
   end
endmodule

// File: rtl/vpl_addr_gen.sv
module vpl_addr_gen #(
   parameter int AW       = 32,
   parameter int IMM_W    = 4,
   parameter int VB_SHIFT = 6,
   parameter int KW       = 3
) (
   input  logic [AW-1:0]           base_addr,
   input  logic signed [IMM_W-1:0] imm,
   input  logic [AW-1:0]           start_q,
   input  logic [KW-1:0]           item,
   output logic [AW-1:0]           start_addr,
   output logic [AW-1:0]           item_addr
);
   import vpl_pkg::*;
   logic [AW-1:0] imm_ext;
   always_comb begin
      imm_ext    = AW'(imm);
      start_addr = base_addr + (imm_ext << VB_SHIFT);
      item_addr  = start_q + (AW'(item) << ITEM_SHIFT);
   end
endmodule

// File: rtl/vpl_lane_store.sv
module vpl_lane_store #(
   parameter int LANES = 4,
   parameter int LW    = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   wr,
   input  logic [LW-1:0]          wr_lane,
   input  logic                   wr_half,
   input  logic [127:0]           wr_data,
   output logic [LANES*128-1:0]   vec_a,
   output logic [LANES*128-1:0]   vec_b
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic hit;
      assign hit = wr && (wr_lane == LW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vec_a[g*128 +: 128] <= '0;
            vec_b[g*128 +: 128] <= '0;
         end else if (clr) begin
            vec_a[g*128 +: 128] <= '0;
            vec_b[g*128 +: 128] <= '0;
         end else if (hit && !wr_half) begin
            vec_a[g*128 +: 128] <= wr_data;
         end else if (hit && wr_half) begin
            vec_b[g*128 +: 128] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/vec_pair_loader.sv
module vec_pair_loader #(
   parameter int VLEN  = 512,
   parameter int AW    = 32,
   parameter int IMM_W = 4,
   localparam int LANES = VLEN / 128,
   localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [AW-1:0]           base_addr,
   input  logic signed [IMM_W-1:0] imm,
   input  logic [LANES-1:0]        pred,
   input  logic [4:0]              dst_idx,
   output logic                    req_valid,
   input  logic                    req_ready,
   output logic [AW-1:0]           req_addr,
   input  logic                    rsp_valid,
   input  logic [127:0]            rsp_data,
   input  logic                    rsp_err,
   output logic                    done,
   output logic                    commit,
   output logic                    fault,
   output logic [LW-1:0]           fault_lane,
   output logic [4:0]              idx_a,
   output logic [4:0]              idx_b,
   output logic [VLEN-1:0]         vec_a,
   output logic [VLEN-1:0]         vec_b
);
   import vpl_pkg::*;

   localparam int FW       = $clog2(LANES + 1);
   localparam int KW       = LW + 1;
   localparam int VB_SHIFT = $clog2(VLEN / 8);

   if (VLEN != 128 && VLEN != 256 && VLEN != 512 && VLEN != 1024 && VLEN != 2048) begin : g_bad_vlen
      $error("VLEN must be 128, 256, 512, 1024 or 2048");
   end
   if (IMM_W < 2 || IMM_W > AW) begin : g_bad_imm
      $error("IMM_W out of range");
   end
   if (AW < 16) begin : g_bad_aw
      $error("AW too small");
   end

   vpl_state_e        state;
   logic [LANES-1:0]  pred_q;
   logic [4:0]        idx_q;
   logic [AW-1:0]     start_q;
   logic [KW-1:0]     k_q;
   logic              done_q;
   logic              fault_q;
   logic [LW-1:0]     fl_q;

   logic [AW-1:0]     start_addr;
   logic [LANES-1:0]  seek_mask;
   logic [FW-1:0]     seek_from;
   logic              seek_found;
   logic [LW-1:0]     seek_lane;
   logic              idle_start;
   logic              accept;

   assign idle_start = (state == ST_IDLE) && start;
   assign accept     = (state == ST_WAIT) && rsp_valid;
   assign seek_mask  = (state == ST_IDLE) ? pred : pred_q;
   assign seek_from  = (state == ST_IDLE) ? '0 : (FW'(k_q[KW-1:1]) + FW'(1));

   vpl_lane_seek #(.LANES(LANES), .LW(LW), .FW(FW)) u_seek (
      .mask  (seek_mask),
      .from  (seek_from),
      .found (seek_found),
      .lane  (seek_lane)
   );

   vpl_addr_gen #(.AW(AW), .IMM_W(IMM_W), .VB_SHIFT(VB_SHIFT), .KW(KW)) u_addr (
      .base_addr  (base_addr),
      .imm        (imm),
      .start_q    (start_q),
      .item       (k_q),
      .start_addr (start_addr),
      .item_addr  (req_addr)
   );

   vpl_lane_store #(.LANES(LANES), .LW(LW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (idle_start),
      .wr      (accept && !rsp_err),
      .wr_lane (k_q[KW-1:1]),
      .wr_half (k_q[0]),
      .wr_data (rsp_data),
      .vec_a   (vec_a),
      .vec_b   (vec_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pred_q  <= '0;
         idx_q   <= '0;
         start_q <= '0;
         k_q     <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         fl_q    <= '0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  pred_q  <= pred;
                  idx_q   <= dst_idx;
                  start_q <= start_addr;
                  fault_q <= 1'b0;
                  fl_q    <= '0;
                  if (seek_found) begin
                     k_q   <= {seek_lane, 1'b0};
                     state <= ST_REQ;
                  end else begin
                     done_q <= 1'b1;
                  end
               end
            end
            ST_REQ: begin
               if (req_ready) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rsp_valid) begin
                  if (rsp_err) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                     fl_q    <= k_q[KW-1:1];
                     state   <= ST_IDLE;
                  end else if (!k_q[0]) begin
                     k_q   <= k_q + KW'(1);
                     state <= ST_REQ;
                  end else if (seek_found) begin
                     k_q   <= {seek_lane, 1'b0};
                     state <= ST_REQ;
                  end else begin
                     done_q <= 1'b1;
                     state  <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_valid  = (state == ST_REQ);
   assign done       = done_q;
   assign fault      = fault_q;
   assign fault_lane = fl_q;
   assign commit     = done_q && !fault_q;
   assign idx_a      = idx_q;
   assign idx_b      = idx_q + 5'd1;
endmodule

// File: rtl/vpl_loader_chk.sv
module vpl_loader_chk #(
   parameter int VLEN  = 512,
   parameter int AW    = 32,
   parameter int IMM_W = 4,
   localparam int LANES = VLEN / 128,
   localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic [AW-1:0]           base_addr,
   input logic signed [IMM_W-1:0] imm,
   input logic [LANES-1:0]        pred,
   input logic                    req_valid,
   input logic                    req_ready,
   input logic [AW-1:0]           req_addr,
   input logic                    rsp_valid,
   input logic                    done,
   input logic [VLEN-1:0]         vec_a,
   input logic [VLEN-1:0]         vec_b
);
   localparam int VB_SHIFT = $clog2(VLEN / 8);

   logic             busy;
   logic             pending;
   logic             have_last;
   logic [AW-1:0]    last_off;
   logic [AW-1:0]    c_start;
   logic [LANES-1:0] c_pred;
   logic [AW-1:0]    off;
   logic             hs;
   logic             take;
   logic [AW-1:0]    imm_ext;

   assign imm_ext = AW'(imm);
   assign hs      = req_valid && req_ready;
   assign take    = start && (!busy || done);
   assign off     = req_addr - c_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         pending   <= 1'b0;
         have_last <= 1'b0;
         last_off  <= '0;
         c_start   <= '0;
         c_pred    <= '0;
      end else begin
         if (take) begin
            busy      <= 1'b1;
            have_last <= 1'b0;
            c_start   <= base_addr + (imm_ext << VB_SHIFT);
            c_pred    <= pred;
         end else if (done) begin
            busy <= 1'b0;
         end
         if (hs) begin
            pending   <= 1'b1;
            have_last <= 1'b1;
            last_off  <= off;
         end else if (rsp_valid) begin
            pending <= 1'b0;
         end
      end
   end

   p_single_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> !req_valid);

   p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && have_last) |-> (off > last_off));

   p_active_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hs |-> c_pred[off[LW+4:5]]);

   p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

   p_empty_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (pred == '0)) |=> done);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !(start && (pred == '0))) |=> !done);

   for (genvar g = 0; g < LANES; g++) begin : g_zero
      p_masked_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (done && !c_pred[g]) |-> ((vec_a[g*128 +: 128] == '0) && (vec_b[g*128 +: 128] == '0)));
   end
endmodule

bind vec_pair_loader vpl_loader_chk #(.VLEN(VLEN), .AW(AW), .IMM_W(IMM_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .base_addr (base_addr),
   .imm       (imm),
   .pred      (pred),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .rsp_valid (rsp_valid),
   .done      (done),
   .vec_a     (vec_a),
   .vec_b     (vec_b)
);

// File: tb/vec_pair_loader_tb.sv
module vec_pair_loader_tb;
   localparam int CLK_PERIOD = 10;
   localparam int VLEN  = 512;
   localparam int LANES = 4;
   localparam int VBYTES = VLEN / 8;
   localparam int WATCHDOG = 100000;
   localparam int NTBL = 8;
   // {dst[53:49], pred[48:45], imm[44:41], base[40:9], stall[8], err_item[7:0]}
   localparam logic [53:0] TBL [NTBL] = '{
      {5'd3,  4'b1111, 4'h0, 32'h0000_1000, 1'b0, 8'hFF},
      {5'd31, 4'b0101, 4'h2, 32'h0000_2000, 1'b1, 8'hFF},
      {5'd0,  4'b1000, 4'hF, 32'h0000_3000, 1'b0, 8'hFF},
      {5'd10, 4'b0110, 4'h8, 32'h0000_0400, 1'b1, 8'hFF},
      {5'd7,  4'b1111, 4'h1, 32'h0000_0013, 1'b1, 8'hFF},
      {5'd1,  4'b1011, 4'h0, 32'h0000_5000, 1'b0, 8'd3},
      {5'd2,  4'b1010, 4'h0, 32'h0000_6000, 1'b1, 8'd2},
      {5'd4,  4'b1100, 4'h0, 32'h0000_7000, 1'b0, 8'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [31:0] base_addr = '0;
   logic signed [3:0] imm = '0;
   logic [LANES-1:0] pred = '0;
   logic [4:0] dst_idx = '0;
   logic req_valid, req_ready;
   logic [31:0] req_addr;
   logic rsp_valid;
   logic [127:0] rsp_data;
   logic rsp_err;
   logic done, commit, fault;
   logic [1:0] fault_lane;
   logic [4:0] idx_a, idx_b;
   logic [VLEN-1:0] vec_a, vec_b;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   logic stall_en = 1'b0;
   logic err_on = 1'b0;
   logic [31:0] err_addr = '0;
   int req_cnt = 0;
   logic [31:0] req_log [64];
   int hold_viol = 0;
   int out_viol = 0;
   logic pend_m = 1'b0;
   logic prev_stall = 1'b0;
   logic [31:0] prev_addr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_pair_loader #(.VLEN(VLEN), .AW(32), .IMM_W(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .imm(imm),
      .pred(pred), .dst_idx(dst_idx), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
      .done(done), .commit(commit), .fault(fault), .fault_lane(fault_lane),
      .idx_a(idx_a), .idx_b(idx_b), .vec_a(vec_a), .vec_b(vec_b));

   function automatic logic [127:0] memf(input logic [31:0] a);
      return {a, ~a, a ^ 32'hA5A5_5A5A, a + 32'h1234_5678};
   endfunction

   // memory model: one-cycle response, optional ready stalls, protocol monitors
   initial begin
      req_ready = 1'b1;
      rsp_valid = 1'b0;
      rsp_data  = '0;
      rsp_err   = 1'b0;
   end
   always @(posedge clk) begin
      cyc <= cyc + 1;
      req_ready <= stall_en ? (cyc[0] ^ cyc[2]) : 1'b1;
      rsp_valid <= 1'b0;
      if (prev_stall && (!req_valid || req_addr != prev_addr)) hold_viol <= hold_viol + 1;
      if (pend_m && req_valid) out_viol <= out_viol + 1;
      prev_stall <= req_valid && !req_ready;
      prev_addr  <= req_addr;
      if (req_valid && req_ready) begin
         rsp_valid <= 1'b1;
         rsp_data  <= memf(req_addr);
         rsp_err   <= err_on && (req_addr == err_addr);
         req_log[req_cnt % 64] <= req_addr;
         req_cnt   <= req_cnt + 1;
         pend_m    <= 1'b1;
      end else if (rsp_valid) begin
         pend_m <= 1'b0;
      end
   end

   always @(posedge clk) begin
      if (cyc == WATCHDOG) begin
         fails = fails + 1;
         $display("FAIL watchdog expired: actual cycles=%0d expected below %0d", cyc, WATCHDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input logic [53:0] e);
      logic [4:0] d = e[53:49];
      logic [3:0] p = e[48:45];
      logic signed [3:0] im = e[44:41];
      logic [31:0] b = e[40:9];
      logic [7:0] ei = e[7:0];
      logic [31:0] st;
      logic [31:0] exp_addr [8];
      int nexp = 0;
      bit exp_fault = 0;
      int exp_fl = 0;
      int base_cnt;
      int w;
      st = b + 32'(int'(im) * VBYTES);
      stall_en = e[8];
      err_on = (ei != 8'hFF);
      err_addr = st + 32'(16 * int'(ei));
      for (int i = 0; i < LANES && !exp_fault; i++) begin
         for (int h = 0; h < 2 && !exp_fault; h++) begin
            if (p[i]) begin
               exp_addr[nexp] = st + 32'(16 * (2 * i + h));
               if (err_on && exp_addr[nexp] == err_addr) begin
                  exp_fault = 1;
                  exp_fl = i;
               end
               nexp++;
            end
         end
      end
      @(negedge clk);
      base_cnt = req_cnt;
      start = 1'b1; base_addr = b; imm = im; pred = p; dst_idx = d;
      @(negedge clk);
      start = 1'b0;
      w = 0;
      while (!done && w < 300) begin
         @(negedge clk);
         w++;
      end
      chk(done == 1'b1, "R9 done seen", 128'(done), 128'd1);
      chk(fault == exp_fault, "R7 fault flag", 128'(fault), 128'(exp_fault));
      chk(commit == !exp_fault, "R9 commit with done", 128'(commit), 128'(!exp_fault));
      if (exp_fault)
         chk(fault_lane == 2'(exp_fl), "R7 fault lane", 128'(fault_lane), 128'(exp_fl));
      chk((req_cnt - base_cnt) == nexp, "R3 request count", 128'(req_cnt - base_cnt), 128'(nexp));
      for (int r = 0; r < nexp && r < (req_cnt - base_cnt); r++)
         chk(req_log[(base_cnt + r) % 64] == exp_addr[r], "R1 R5 request address",
             128'(req_log[(base_cnt + r) % 64]), 128'(exp_addr[r]));
      if (!exp_fault) begin
         for (int i = 0; i < LANES; i++) begin
            logic [127:0] ea = p[i] ? memf(st + 32'(32 * i)) : '0;
            logic [127:0] eb = p[i] ? memf(st + 32'(32 * i + 16)) : '0;
            chk(vec_a[i*128 +: 128] == ea, p[i] ? "R2 lane of A" : "R4 masked lane of A", vec_a[i*128 +: 128], ea);
            chk(vec_b[i*128 +: 128] == eb, p[i] ? "R2 lane of B" : "R4 masked lane of B", vec_b[i*128 +: 128], eb);
         end
      end
      chk(idx_a == d, "R10 idx_a", 128'(idx_a), 128'(d));
      chk(idx_b == d + 5'd1, "R10 idx_b", 128'(idx_b), 128'(5'(d + 5'd1)));
      @(negedge clk);
      chk(done == 1'b0, "R9 done is one cycle", 128'(done), 128'd0);
      chk(hold_viol == 0, "R11 stalled request held", 128'(hold_viol), 128'd0);
      chk(out_viol == 0, "R6 single outstanding", 128'(out_viol), 128'd0);
      chk((req_cnt - base_cnt) == nexp, "R7 no request after fault", 128'(req_cnt - base_cnt), 128'(nexp));
   endtask

   initial begin
      int c0;
      repeat (3) @(negedge clk);
      chk(done == 1'b0 && req_valid == 1'b0, "R9 reset: idle outputs", 128'({done, req_valid}), 128'd0);
      chk(vec_a == '0 && vec_b == '0, "R4 reset: vectors zero", 128'(vec_a[127:0]), 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int t = 0; t < NTBL; t++) run(TBL[t]);
      // all-lanes-masked: done exactly one cycle after start, no traffic (R8)
      stall_en = 1'b0;
      @(negedge clk);
      c0 = req_cnt;
      start = 1'b1; pred = 4'b0000; dst_idx = 5'd31; base_addr = 32'h8000; imm = 4'sd0;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, "R8 done one cycle after start", 128'(done), 128'd1);
      chk(commit == 1'b1, "R8 commit on empty predicate", 128'(commit), 128'd1);
      chk(vec_a == '0 && vec_b == '0, "R4 empty predicate zero vectors", 128'(vec_a[127:0] | vec_b[127:0]), 128'd0);
      chk(idx_b == 5'd0, "R10 register wrap", 128'(idx_b), 128'd0);
      repeat (3) @(negedge clk);
      chk(req_cnt == c0, "R8 no request issued", 128'(req_cnt - c0), 128'd0);
      // a full load after the empty one still works
      run({5'd5, 4'b1111, 4'h3, 32'h0000_9000, 1'b0, 8'hFF});
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule